// File: doc/BRIEF.md
# DMA Channel Register Bank with Split 64-bit Access

This block holds the per-channel programming and status registers of a small memory-to-memory DMA controller. Each channel has a 32-bit control word and a 32-bit pending-configuration word. It also has three 64-bit pending fields: transfer length, destination address and source address. A second set of registers mirrors what the transfer engine is executing: a configuration word and length, destination and source values. Software reaches all of them over one memory-mapped request/response port that carries 4-byte and 8-byte accesses. The pending values go out to the transfer engine on flat per-channel buses. The engine writes the executing copies back through a per-channel load strobe.

Each 64-bit field can be reached whole with one 8-byte access at its base offset. It can also be reached one half at a time with 4-byte accesses at base (bits 31:0) and base+4 (bits 63:32). A half write leaves the other half unchanged. The executing copies cannot be changed from the bus at any width.

The request side is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect at that edge and produces no response. A read produces exactly one response, and `rsp_valid` rises one cycle after acceptance. The response holds `rsp_rdata` steady until `rsp_ready` is seen high. `req_ready` is low while a response is waiting and `rsp_ready` is low, so only one read is ever outstanding.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register of every channel reads as zero and every engine-facing output is zero.
- R2: The address is {channel, 12-bit offset}, and only the low 12 bits are decoded as the offset. The per-channel offsets are: control 0x000, pending config 0x004, pending length 0x008, pending destination 0x010, pending source 0x018, executing config 0x104, executing length 0x108, executing destination 0x110, executing source 0x118. A 4-byte write at a 64-bit field's base replaces bits 31:0 only, and at base+4 it replaces bits 63:32 only. Either write takes its value from `req_wdata[31:0]`. The pending values appear on the engine outputs of their channel, with channel i in slice i, and no other channel changes.
- R3: A 4-byte read at a 64-bit field's base returns bits 31:0, and at base+4 it returns bits 63:32. Both are zero-extended.
- R4: An 8-byte read or write at a 64-bit field's base transfers all 64 bits. An 8-byte access at base+4 reads zero and writes nothing.
- R5: The executing registers ignore bus writes of 4 or 8 bytes, including writes at their high halves. They load only when the engine raises `eng_ld` for that channel, and they read back what was loaded.
- R6: An access whose channel field is not below NCH reads zero and writes nothing. It does not alias onto any implemented channel.
- R7: An access whose `req_size` is neither 4 nor 8 reads zero and writes nothing.
- R8: An access to an undefined offset, or with a width the offset does not allow, reads zero and writes nothing. An 8-byte access to the control word is one such case.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: channel above bit 11, offset in bits 11:0 |
| req_size | input | 4 | Access size in bytes (4 or 8 legal) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 64 | Read data |
| nx_ctrl | output | NCH*32 | Control word of each channel |
| nx_cfg | output | NCH*32 | Pending config of each channel |
| nx_bytes | output | NCH*64 | Pending length of each channel |
| nx_dst | output | NCH*64 | Pending destination of each channel |
| nx_src | output | NCH*64 | Pending source of each channel |
| eng_ld | input | NCH | Load executing copies of channel i |
| eng_cfg | input | NCH*32 | Executing config to load |
| eng_bytes | input | NCH*64 | Executing length to load |
| eng_dst | input | NCH*64 | Executing destination to load |
| eng_src | input | NCH*64 | Executing source to load |

## Verification
The hardest case to reach from the ports is a read response held under back-pressure while a new request waits. The stimulus drops `rsp_ready`, launches a read, and then over several cycles confirms that the data holds and the request side stays closed. The read-only executing copies only carry non-zero values once the engine strobe has loaded them. The bench therefore loads them first and then attacks them with writes at every width and half. An alias check writes through channel 5, which truncates onto channel 1. It then reads channel 1 back to confirm that nothing landed there.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_NCFG, RG_NBYTES, RG_NDST, RG_NSRC,
    RG_ECFG, RG_EBYTES, RG_EDST, RG_ESRC
  } reg_id_e;

  typedef enum logic [1:0] {PT_LO, PT_HI, PT_FULL} part_e;

  typedef struct packed {
    logic    hit;
    reg_id_e id;
    part_e   part;
  } acc_s;

  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_NCFG   = 12'h004;
  localparam logic [11:0] OFF_NBYTES = 12'h008;
  localparam logic [11:0] OFF_NDST   = 12'h010;
  localparam logic [11:0] OFF_NSRC   = 12'h018;
  localparam logic [11:0] OFF_ECFG   = 12'h104;
  localparam logic [11:0] OFF_EBYTES = 12'h108;
  localparam logic [11:0] OFF_EDST   = 12'h110;
  localparam logic [11:0] OFF_ESRC   = 12'h118;

  // Offset + size -> register and part. 64-bit fields allow 8 bytes at base
  // and 4 bytes at base or base+4; 32-bit words allow 4 bytes only.
  function automatic acc_s decode_offset(input logic [11:0] off,
                                         input logic [3:0]  sz);
    acc_s    a;
    reg_id_e wide;
    logic [11:0] base;
    a.hit  = 1'b0;
    a.id   = RG_NONE;
    a.part = PT_LO;
    base   = {off[11:3], 3'b000};
    case (base)
      OFF_NBYTES: wide = RG_NBYTES;
      OFF_NDST:   wide = RG_NDST;
      OFF_NSRC:   wide = RG_NSRC;
      OFF_EBYTES: wide = RG_EBYTES;
      OFF_EDST:   wide = RG_EDST;
      OFF_ESRC:   wide = RG_ESRC;
      default:    wide = RG_NONE;
    endcase
    if (sz == 4'd4 && (off == OFF_CTRL || off == OFF_NCFG || off == OFF_ECFG)) begin
      a.hit = 1'b1;
      a.id  = (off == OFF_CTRL) ? RG_CTRL : ((off == OFF_NCFG) ? RG_NCFG : RG_ECFG);
    end else if (wide != RG_NONE && off[1:0] == 2'b00) begin
      if (!off[2] && sz == 4'd8) begin
        a.hit = 1'b1; a.id = wide; a.part = PT_FULL;
      end else if (sz == 4'd4) begin
        a.hit = 1'b1; a.id = wide; a.part = off[2] ? PT_HI : PT_LO;
      end
    end
    return a;
  endfunction

  function automatic logic [63:0] merge64(input logic [63:0] old,
                                          input part_e p,
                                          input logic [63:0] wd);
    case (p)
      PT_FULL: return wd;
      PT_HI:   return {wd[31:0], old[31:0]};
      default: return {old[63:32], wd[31:0]};
    endcase
  endfunction

  function automatic logic [63:0] view64(input logic [63:0] r, input part_e p);
    case (p)
      PT_FULL: return r;
      PT_HI:   return {32'h0, r[63:32]};
      default: return {32'h0, r[31:0]};
    endcase
  endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output acc_s              acc,
  output logic [CH_W-1:0]   ch
);
  localparam int FIELD_W = ADDR_W - 12;

  logic [FIELD_W-1:0] field;
  logic               in_range;
  acc_s               raw;

  assign field    = addr[ADDR_W-1:12];
  assign in_range = int'(field) < NCH;
  assign raw      = decode_offset(addr[11:0], size);
  assign ch       = CH_W'(field);

  always_comb begin
    acc = raw;
    if (!in_range) begin
      acc.hit = 1'b0;
      acc.id  = RG_NONE;
    end
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  acc_s        acc,
  input  logic [63:0] wdata,
  input  logic        ld,
  input  logic [31:0] ld_cfg,
  input  logic [63:0] ld_bytes,
  input  logic [63:0] ld_dst,
  input  logic [63:0] ld_src,
  output logic [31:0] ctrl_q,
  output logic [31:0] ncfg_q,
  output logic [63:0] nbytes_q,
  output logic [63:0] ndst_q,
  output logic [63:0] nsrc_q,
  output logic [63:0] rd_data
);
  logic [31:0] ecfg_q;
  logic [63:0] ebytes_q, edst_q, esrc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ncfg_q   <= '0;
      nbytes_q <= '0;
      ndst_q   <= '0;
      nsrc_q   <= '0;
    end else if (wr_en && acc.hit) begin
      case (acc.id)
        RG_CTRL:   ctrl_q   <= wdata[31:0];
        RG_NCFG:   ncfg_q   <= wdata[31:0];
        RG_NBYTES: nbytes_q <= merge64(nbytes_q, acc.part, wdata);
        RG_NDST:   ndst_q   <= merge64(ndst_q, acc.part, wdata);
        RG_NSRC:   nsrc_q   <= merge64(nsrc_q, acc.part, wdata);
        default: ;
      endcase
    end
  end

  // Executing copies: engine-loaded only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecfg_q   <= '0;
      ebytes_q <= '0;
      edst_q   <= '0;
      esrc_q   <= '0;
    end else if (ld) begin
      ecfg_q   <= ld_cfg;
      ebytes_q <= ld_bytes;
      edst_q   <= ld_dst;
      esrc_q   <= ld_src;
    end
  end

  always_comb begin
    rd_data = '0;
    if (acc.hit) begin
      case (acc.id)
        RG_CTRL:   rd_data = {32'h0, ctrl_q};
        RG_NCFG:   rd_data = {32'h0, ncfg_q};
        RG_ECFG:   rd_data = {32'h0, ecfg_q};
        RG_NBYTES: rd_data = view64(nbytes_q, acc.part);
        RG_NDST:   rd_data = view64(ndst_q, acc.part);
        RG_NSRC:   rd_data = view64(nsrc_q, acc.part);
        RG_EBYTES: rd_data = view64(ebytes_q, acc.part);
        RG_EDST:   rd_data = view64(edst_q, acc.part);
        RG_ESRC:   rd_data = view64(esrc_q, acc.part);
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic [NCH*32-1:0] nx_ctrl,
  output logic [NCH*32-1:0] nx_cfg,
  output logic [NCH*64-1:0] nx_bytes,
  output logic [NCH*64-1:0] nx_dst,
  output logic [NCH*64-1:0] nx_src,
  input  logic [NCH-1:0]    eng_ld,
  input  logic [NCH*32-1:0] eng_cfg,
  input  logic [NCH*64-1:0] eng_bytes,
  input  logic [NCH*64-1:0] eng_dst,
  input  logic [NCH*64-1:0] eng_src
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  acc_s            acc;
  logic [CH_W-1:0] ch;
  logic            fire;
  logic [63:0]     bank_rd [NCH];
  logic [63:0]     rd_sel;

  dma_reg_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size), .acc(acc), .ch(ch)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fire && req_write && ch == CH_W'(i)),
      .acc      (acc),
      .wdata    (req_wdata),
      .ld       (eng_ld[i]),
      .ld_cfg   (eng_cfg[i*32 +: 32]),
      .ld_bytes (eng_bytes[i*64 +: 64]),
      .ld_dst   (eng_dst[i*64 +: 64]),
      .ld_src   (eng_src[i*64 +: 64]),
      .ctrl_q   (nx_ctrl[i*32 +: 32]),
      .ncfg_q   (nx_cfg[i*32 +: 32]),
      .nbytes_q (nx_bytes[i*64 +: 64]),
      .ndst_q   (nx_dst[i*64 +: 64]),
      .nsrc_q   (nx_src[i*64 +: 64]),
      .rd_data  (bank_rd[i])
    );
  end

  assign rd_sel = acc.hit ? bank_rd[ch] : 64'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [63:0]       rsp_rdata,
  input logic [NCH*32-1:0] nx_ctrl,
  input logic [NCH*32-1:0] nx_cfg,
  input logic [NCH*64-1:0] nx_bytes,
  input logic [NCH*64-1:0] nx_dst,
  input logic [NCH*64-1:0] nx_src
);
  logic acc_fire, bad_ch, bad_sz;
  assign acc_fire = req_valid && req_ready;
  assign bad_ch   = int'(req_addr[ADDR_W-1:12]) >= NCH;
  assign bad_sz   = req_size != 4'd4 && req_size != 4'd8;

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r6_bad_ch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !req_write && bad_ch |=> rsp_valid && rsp_rdata == 64'h0);

  a_r7_bad_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !req_write && bad_sz |=> rsp_valid && rsp_rdata == 64'h0);

  a_r5_exec_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && req_write && req_addr[8] |=>
      $stable(nx_ctrl) && $stable(nx_cfg) && $stable(nx_bytes) &&
      $stable(nx_dst) && $stable(nx_src));

  a_r8_ctrl_wide_inert: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && req_write && req_size == 4'd8 && req_addr[11:0] == 12'h000 |=>
      $stable(nx_ctrl));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .nx_ctrl(nx_ctrl), .nx_cfg(nx_cfg), .nx_bytes(nx_bytes),
  .nx_dst(nx_dst), .nx_src(nx_src)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = 4'd4;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic [NCH*32-1:0] nx_ctrl, nx_cfg;
  logic [NCH*64-1:0] nx_bytes, nx_dst, nx_src;
  logic [NCH-1:0] eng_ld = '0;
  logic [NCH*32-1:0] eng_cfg = '0;
  logic [NCH*64-1:0] eng_bytes = '0, eng_dst = '0, eng_src = '0;

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .ADDR_W(AW)) uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input int ch, input logic [11:0] off,
                       input logic [3:0] sz, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_wdata = wd;
    req_addr  = {ch[AW-13:0], off};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [11:0] off, input logic [3:0] sz,
                    input logic [63:0] wd);
    issue(1'b1, ch, off, sz, wd);
  endtask

  task automatic rd(input int ch, input logic [11:0] off, input logic [3:0] sz,
                    input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, ch, off, sz, 64'h0);
  endtask

  // Monitor: compare each delivered read response against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: unexpected response %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 nx_ctrl", {32'h0, nx_ctrl[31:0]} | {32'h0, nx_cfg[127:96]}, 64'h0);
    check("R1 nx_dst", nx_dst[63:0] | nx_src[255:192] | nx_bytes[127:64], 64'h0);
    rd(0, 12'h000, 4'd4, 64'h0, "R1 ctrl read");
    rd(2, 12'h108, 4'd8, 64'h0, "R1 exec bytes read");

    // R2/R3 half writes and reads on channel 1 destination
    wr(1, 12'h010, 4'd4, 64'hDEAD_BEEF_8000_0000);
    wr(1, 12'h014, 4'd4, 64'h0000_0000_0000_0002);
    rd(1, 12'h010, 4'd4, 64'h0000_0000_8000_0000, "R3 low half");
    rd(1, 12'h014, 4'd4, 64'h0000_0000_0000_0002, "R3 high half");
    rd(1, 12'h010, 4'd8, 64'h0000_0002_8000_0000, "R2 combined");
    wr(1, 12'h010, 4'd4, 64'h0000_0000_0000_1111);
    rd(1, 12'h010, 4'd8, 64'h0000_0002_0000_1111, "R2 high preserved");
    @(negedge clk);
    check("R2 nx_dst ch1", nx_dst[127:64], 64'h0000_0002_0000_1111);
    check("R2 nx_dst ch0 untouched", nx_dst[63:0], 64'h0);

    // R4 full-width access
    wr(2, 12'h008, 4'd8, 64'h0123_4567_89AB_CDEF);
    rd(2, 12'h008, 4'd8, 64'h0123_4567_89AB_CDEF, "R4 full read");
    rd(2, 12'h00C, 4'd8, 64'h0, "R4 wide at base+4 reads zero");
    wr(2, 12'h00C, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2, 12'h008, 4'd8, 64'h0123_4567_89AB_CDEF, "R4 wide at base+4 ignored");
    wr(2, 12'h018, 4'd8, 64'hCAFE_0000_0000_F00D);
    @(negedge clk);
    check("R4 nx_src ch2", nx_src[191:128], 64'hCAFE_0000_0000_F00D);

    // R5 executing copies
    @(negedge clk);
    eng_cfg[127:96]   = 32'h0000_00A5;
    eng_bytes[255:192] = 64'h0000_0003_0000_0010;
    eng_dst[255:192]  = 64'h0000_0004_0000_2000;
    eng_src[255:192]  = 64'h0000_0005_0000_3000;
    eng_ld[3] = 1'b1;
    @(negedge clk);
    eng_ld[3] = 1'b0;
    rd(3, 12'h104, 4'd4, 64'h0000_00A5, "R5 exec cfg loaded");
    rd(3, 12'h108, 4'd8, 64'h0000_0003_0000_0010, "R5 exec bytes loaded");
    rd(3, 12'h10C, 4'd4, 64'h3, "R5 exec bytes high half");
    wr(3, 12'h104, 4'd4, 64'hFFFF_FFFF);
    wr(3, 12'h108, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3, 12'h10C, 4'd4, 64'hFFFF_FFFF);
    wr(3, 12'h110, 4'd4, 64'hFFFF_FFFF);
    wr(3, 12'h11C, 4'd4, 64'hFFFF_FFFF);
    rd(3, 12'h104, 4'd4, 64'h0000_00A5, "R5 exec cfg kept");
    rd(3, 12'h108, 4'd8, 64'h0000_0003_0000_0010, "R5 exec bytes kept");
    rd(3, 12'h110, 4'd8, 64'h0000_0004_0000_2000, "R5 exec dst kept");
    rd(3, 12'h118, 4'd8, 64'h0000_0005_0000_3000, "R5 exec src kept");

    // R6 channel out of range, 5 would alias to 1 if truncated
    wr(5, 12'h000, 4'd4, 64'hFF);
    rd(5, 12'h010, 4'd8, 64'h0, "R6 bad channel reads zero");
    rd(1, 12'h000, 4'd4, 64'h0, "R6 no alias write");

    // R7 illegal size
    wr(0, 12'h000, 4'd2, 64'h55);
    rd(0, 12'h000, 4'd4, 64'h0, "R7 size-2 write ignored");
    rd(1, 12'h010, 4'd2, 64'h0, "R7 size-2 read zero");

    // R8 undefined offsets and wrong widths
    wr(0, 12'h000, 4'd8, 64'h0000_0009_0000_0007);
    rd(0, 12'h000, 4'd4, 64'h0, "R8 wide ctrl write ignored");
    wr(0, 12'h020, 4'd4, 64'h77);
    rd(0, 12'h020, 4'd4, 64'h0, "R8 undefined offset");
    wr(0, 12'h000, 4'd4, 64'h3);
    rd(0, 12'h000, 4'd8, 64'h0, "R8 wide ctrl read zero");
    rd(0, 12'h000, 4'd4, 64'h3, "R8 ctrl narrow ok");

    // R9 back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(1, 12'h014, 4'd4, 64'h2, "R9 held read");
    for (int k = 0; k < 3; k++) begin
      check("R9 rsp_valid held", {63'h0, rsp_valid}, 64'h1);
      check("R9 req_ready low", {63'h0, req_ready}, 64'h0);
      check("R9 rdata stable", rsp_rdata, 64'h2);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);
    check("R2 nx_ctrl ch0", {32'h0, nx_ctrl[31:0]}, 64'h3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule